// File: doc/BRIEF.md
# Network statistics counter bank

This block keeps six running statistics for an Ethernet port. Transmit, receive and broadcast traffic each get a packet counter and an octet counter. The transmit and receive pairs are `WIDE_W` bits wide (32 by default). The broadcast pair is `NARROW_W` bits wide (16 by default). A one-cycle event strobe together with a frame byte count advances the matching pair: the packet counter by one, and the octet counter by the byte count. The MAC can also report a broadcast frame that its address filter discarded. That frame reaches the broadcast pair only when software has enabled it.

Software uses a small word-addressed register port. It reads counters through a combinational read path qualified by byte-lane strobes. It writes a control register that holds these settings:

- freeze counting
- saturate at the maximum instead of wrapping
- clear a counter when its lowest byte lane is read
- choose the preset level
- count dropped broadcasts

The control register also takes two one-shot commands: zero everything, and load the test presets. The test presets sit just below the half-way point or just below the top of each counter. This lets software reach the half-full and full conditions with only a few frames. Those conditions set sticky per-counter flags, and a masked OR of the flags drives one interrupt line.

Top module: `stat_bank`

## Requirements
- R1: Writing 1 to control bit 5 zeroes all six counters on the following clock edge. Control bit 5 reads back 1 for exactly that one cycle and 0 afterwards.
- R2: Writing 1 to control bit 6 loads a preset on the following clock edge. The preset depends on control bit 3 (0 = almost-half, 1 = almost-full) and is shown below. Bit 6 reads back 1 for that one cycle only.

| Level | Wide octet | Wide packet | Narrow octet | Narrow packet |
|---|---|---|---|---|
| Almost-half | 0x7FFF_F800 | 0x7FFF_FFF0 | 0x7800 | 0x7FF0 |
| Almost-full | 0xFFFF_F800 | 0xFFFF_FFF0 | 0xF800 | 0xFFF0 |

- R3: A single control write with both bit 5 and bit 6 set zeroes every counter, and bit 6 never reads back as 1.
- R4: On `tx_good` the packet counter at address 1 adds 1 and the octet counter at address 2 adds `tx_bytes`. On `rx_good` the counters at addresses 3 and 4 do the same with `rx_bytes`. On `rx_bcast` the narrow counters at addresses 5 (packets) and 6 (octets) do the same with `rx_bytes`. Transmit and receive events in the same cycle are both counted.
- R5: With control bit 1 at 0, a counter that passes its all-ones value wraps modulo 2^width.
- R6: With control bit 1 at 1, a counter whose sum would pass all-ones stays at all-ones.
- R7: With control bit 2 at 1, a read of a counter zeroes it only when `reg_rd_be[0]` is set. A read with only lanes 3:1 strobed leaves it unchanged, and with bit 2 at 0 no read changes any counter. `reg_rdata` is zero unless `reg_rd` is high with at least one lane strobe set.
- R8: When a clearing read and an event for the same counter fall in the same cycle, the counter reloads with that event's increment.
- R9: With control bit 0 at 1, events change no counter, but a clearing read (R7) still zeroes the counter read.
- R10: `rx_bcast_drop` advances the counters at addresses 5 and 6 only while control bit 4 is 1, and has no effect otherwise.
- R11: The flag register at address 8 holds the half flags of counters 0..5 (address minus 1) in bits 5:0 and their full flags in bits 11:6. A half flag sets when counting moves the counter's top bit from 0 to 1. A full flag sets when counting passes all-ones, whether the counter wraps or saturates. Flags are sticky, and writing 1 to a flag bit clears it.
- R12: `irq` is high exactly when some counter i has its half or full flag set while bit i of the mask register at address 9 is 1.
- R13: Register addresses: 0 is control, 1..6 are the counters, 8 is flags, and 9 is the mask. Unused control bits and unmapped addresses read as zero, and every register reads zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_good | input | 1 | One-cycle strobe for a good transmitted frame |
| tx_bytes | input | BYTE_W | Byte count of the transmitted frame |
| rx_good | input | 1 | One-cycle strobe for a good received frame |
| rx_bcast | input | 1 | One-cycle strobe for a received broadcast frame |
| rx_bcast_drop | input | 1 | One-cycle strobe for a broadcast frame discarded by the filter |
| rx_bytes | input | BYTE_W | Byte count of the received or discarded frame |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 2*NUM_CNT | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rd_be | input | 4 | Read byte-lane strobes; lane 0 triggers clear-on-read |
| reg_rdata | output | RDATA_W | Combinational read data |
| irq | output | 1 | Masked OR of all counter flags |

## Verification
Frames of several sizes, including zero-byte frames, check that packet and octet counters advance by different amounts. Zero-byte frames also let the packet counters be pushed across the half-way and top boundaries without moving the octet counters. Frames that arrive together on the transmit and receive sides show that neither side steals an update from the other. Dropped broadcasts are sent with the enable off and then on. Reads with different lane strobes, some in the same cycle as an event, separate a real clear from a lost event and from a read with no effect. Runs started from both preset levels, first with wrapping and then with saturation, tell the two overflow behaviours apart and show which flag each boundary sets.

// File: rtl/stat_pkg.sv
package stat_pkg;
    // counter arrangement: one packet and one octet counter per traffic source
    typedef enum logic [1:0] {
        SRC_TX    = 2'd0,
        SRC_RX    = 2'd1,
        SRC_BCAST = 2'd2
    } src_e;

    localparam int NUM_SRC = 3;
    localparam int NUM_CNT = 2 * NUM_SRC;

    // control register layout
    localparam int BIT_FREEZE = 0;
    localparam int BIT_SAT    = 1;
    localparam int BIT_RDCLR  = 2;
    localparam int BIT_PFULL  = 3;
    localparam int BIT_DROP   = 4;
    localparam int BIT_CLR    = 5;
    localparam int BIT_PRESET = 6;
    localparam int CTRL_W     = 7;

    // register addresses
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_CNT0  = 1;
    localparam int ADDR_FLAGS = 8;
    localparam int ADDR_MASK  = 9;

    typedef struct packed {
        logic count_drop;
        logic preset_full;
        logic clr_on_rd;
        logic saturate;
        logic freeze;
    } ctrl_t;

    function automatic src_e cnt_src(input int idx);
        return src_e'(idx / 2);
    endfunction

    function automatic bit cnt_is_octet(input int idx);
        return (idx % 2) == 1;
    endfunction
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
    parameter int CNT_W    = 32,
    parameter bit IS_OCTET = 1'b0,
    parameter int BYTE_W   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              preset,
    input  logic              preset_full,
    input  logic              freeze,
    input  logic              saturate,
    input  logic              rd_clear,
    input  logic              event_en,
    input  logic [BYTE_W-1:0] byte_cnt,
    output logic [CNT_W-1:0]  count,
    output logic              half_hit,
    output logic              full_hit
);
    localparam int              GAP      = IS_OCTET ? 2048 : 16;
    localparam logic [CNT_W-1:0] GAP_V   = CNT_W'(GAP);
    localparam logic [CNT_W-1:0] MAX_V   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] PRE_FULL = {CNT_W{1'b0}} - GAP_V;
    localparam logic [CNT_W-1:0] PRE_HALF = {1'b0, {(CNT_W-1){1'b1}}} - GAP_V + CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t      st_d, st_q;
    logic [CNT_W:0]  step;
    logic [CNT_W:0]  total;

    always_comb begin
        st_d     = st_q;
        half_hit = 1'b0;
        full_hit = 1'b0;
        step     = '0;
        if (event_en && !freeze) begin
            if (IS_OCTET) step = (CNT_W+1)'(byte_cnt);
            else          step = (CNT_W+1)'(1);
        end
        total = {1'b0, st_q.count} + step;
        if (clr_all) begin
            st_d.count = '0;
        end else if (preset) begin
            st_d.count = preset_full ? PRE_FULL : PRE_HALF;
        end else if (rd_clear) begin
            // reload with this cycle's increment so a coinciding event survives
            st_d.count = step[CNT_W-1:0];
        end else begin
            if (total[CNT_W]) begin
                full_hit   = 1'b1;
                st_d.count = saturate ? MAX_V : total[CNT_W-1:0];
            end else begin
                st_d.count = total[CNT_W-1:0];
            end
            half_hit = !st_q.count[CNT_W-1] && st_d.count[CNT_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> count == '0);

    assert_preset_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && !clr_all) |=> count == ($past(preset_full) ? PRE_FULL : PRE_HALF));

    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (saturate && count == MAX_V && !clr_all && !preset && !rd_clear) |=> count == MAX_V);

    assert_rdclr_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !clr_all && !preset && !event_en) |=> count == '0);

    assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !clr_all && !preset && !rd_clear) |=> $stable(count));
endmodule

// File: rtl/stat_ctrl.sv
module stat_ctrl
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             cfg,
    output logic              clr_pulse,
    output logic              preset_pulse
);
    typedef struct packed {
        ctrl_t cfg;
        logic  clr;
        logic  pre;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        st_d.pre = 1'b0;
        if (wr_en) begin
            st_d.cfg.freeze      = wr_data[BIT_FREEZE];
            st_d.cfg.saturate    = wr_data[BIT_SAT];
            st_d.cfg.clr_on_rd   = wr_data[BIT_RDCLR];
            st_d.cfg.preset_full = wr_data[BIT_PFULL];
            st_d.cfg.count_drop  = wr_data[BIT_DROP];
            st_d.clr             = wr_data[BIT_CLR];
            // clear has priority: a preset in the same write never latches
            st_d.pre             = wr_data[BIT_PRESET] && !wr_data[BIT_CLR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg          = st_q.cfg;
    assign clr_pulse    = st_q.clr;
    assign preset_pulse = st_q.pre;

    assert_clr_self_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !(wr_en && wr_data[BIT_CLR])) |=> !clr_pulse);

    assert_preset_self_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_pulse && !(wr_en && wr_data[BIT_PRESET])) |=> !preset_pulse);

    assert_clear_beats_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_CLR]) |=> (clr_pulse && !preset_pulse));
endmodule

// File: rtl/stat_irq.sv
module stat_irq #(
    parameter int N = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   half_hit,
    input  logic [N-1:0]   full_hit,
    input  logic           flag_wr,
    input  logic           mask_wr,
    input  logic [2*N-1:0] wr_data,
    output logic [N-1:0]   half_flags,
    output logic [N-1:0]   full_flags,
    output logic [N-1:0]   mask,
    output logic           irq
);
    typedef struct packed {
        logic [N-1:0] half;
        logic [N-1:0] full;
        logic [N-1:0] mask;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flag_wr) begin
            st_d.half = st_d.half & ~wr_data[N-1:0];
            st_d.full = st_d.full & ~wr_data[2*N-1:N];
        end
        // a new hit wins over a clear in the same cycle
        st_d.half = st_d.half | half_hit;
        st_d.full = st_d.full | full_hit;
        if (mask_wr) st_d.mask = wr_data[N-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign half_flags = st_q.half;
    assign full_flags = st_q.full;
    assign mask       = st_q.mask;
    assign irq        = |((st_q.half | st_q.full) & st_q.mask);

    assert_half_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|half_hit) |=> ((half_flags & $past(half_hit)) == $past(half_hit)));

    assert_full_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|full_hit) |=> ((full_flags & $past(full_hit)) == $past(full_hit)));

    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr && !(|half_hit) && !(|full_hit)) |=> $stable({half_flags, full_flags}));

    assert_irq_raise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((|((half_hit | full_hit) & mask)) && !mask_wr) |=> irq);
endmodule

// File: rtl/stat_bank.sv
module stat_bank
    import stat_pkg::*;
#(
    parameter int WIDE_W   = 32,
    parameter int NARROW_W = 16,
    parameter int BYTE_W   = 14,
    parameter int ADDR_W   = 4,
    parameter int RDATA_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_good,
    input  logic [BYTE_W-1:0]    tx_bytes,
    input  logic                 rx_good,
    input  logic                 rx_bcast,
    input  logic                 rx_bcast_drop,
    input  logic [BYTE_W-1:0]    rx_bytes,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [2*NUM_CNT-1:0] reg_wdata,
    input  logic                 reg_rd,
    input  logic [3:0]           reg_rd_be,
    output logic [RDATA_W-1:0]   reg_rdata,
    output logic                 irq
);
    localparam int BC0 = 2 * int'(SRC_BCAST);

    ctrl_t                 cfg;
    logic                  clr_pulse;
    logic                  preset_pulse;
    logic                  ctrl_wr;
    logic                  flag_wr;
    logic                  mask_wr;
    logic                  rd_active;
    logic                  drop_counted;
    logic [NUM_CNT-1:0]    ev;
    logic [NUM_CNT-1:0]    rd_clr;
    logic [NUM_CNT-1:0]    half_hit;
    logic [NUM_CNT-1:0]    full_hit;
    logic [NUM_CNT-1:0]    half_flags;
    logic [NUM_CNT-1:0]    full_flags;
    logic [NUM_CNT-1:0]    irq_mask;
    logic [RDATA_W-1:0]    cnt_val [NUM_CNT];
    logic [RDATA_W-1:0]    rd_mux;

    assign ctrl_wr      = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
    assign flag_wr      = reg_wr && (reg_addr == ADDR_W'(ADDR_FLAGS));
    assign mask_wr      = reg_wr && (reg_addr == ADDR_W'(ADDR_MASK));
    assign rd_active    = reg_rd && (|reg_rd_be);
    assign drop_counted = rx_bcast_drop && cfg.count_drop;

    stat_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (ctrl_wr),
        .wr_data      (reg_wdata[CTRL_W-1:0]),
        .cfg          (cfg),
        .clr_pulse    (clr_pulse),
        .preset_pulse (preset_pulse)
    );

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        localparam src_e SRC = cnt_src(gi);
        localparam int   W   = (SRC == SRC_BCAST) ? NARROW_W : WIDE_W;

        logic [W-1:0]      value;
        logic [BYTE_W-1:0] bytes_sel;

        assign ev[gi]     = (SRC == SRC_TX) ? tx_good :
                            (SRC == SRC_RX) ? rx_good : (rx_bcast || drop_counted);
        assign bytes_sel  = (SRC == SRC_TX) ? tx_bytes : rx_bytes;
        assign rd_clr[gi] = rd_active && reg_rd_be[0] && cfg.clr_on_rd &&
                            (reg_addr == ADDR_W'(ADDR_CNT0 + gi));

        stat_counter #(
            .CNT_W    (W),
            .IS_OCTET (cnt_is_octet(gi)),
            .BYTE_W   (BYTE_W)
        ) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .clr_all     (clr_pulse),
            .preset      (preset_pulse),
            .preset_full (cfg.preset_full),
            .freeze      (cfg.freeze),
            .saturate    (cfg.saturate),
            .rd_clear    (rd_clr[gi]),
            .event_en    (ev[gi]),
            .byte_cnt    (bytes_sel),
            .count       (value),
            .half_hit    (half_hit[gi]),
            .full_hit    (full_hit[gi])
        );

        assign cnt_val[gi] = RDATA_W'(value);
    end

    stat_irq #(.N(NUM_CNT)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_hit   (half_hit),
        .full_hit   (full_hit),
        .flag_wr    (flag_wr),
        .mask_wr    (mask_wr),
        .wr_data    (reg_wdata),
        .half_flags (half_flags),
        .full_flags (full_flags),
        .mask       (irq_mask),
        .irq        (irq)
    );

    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL))  rd_mux = RDATA_W'({preset_pulse, clr_pulse, cfg});
        if (reg_addr == ADDR_W'(ADDR_FLAGS)) rd_mux = RDATA_W'({full_flags, half_flags});
        if (reg_addr == ADDR_W'(ADDR_MASK))  rd_mux = RDATA_W'(irq_mask);
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr == ADDR_W'(ADDR_CNT0 + i)) rd_mux = cnt_val[i];
        end
    end

    assign reg_rdata = rd_active ? rd_mux : '0;

    assert_drop_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bcast_drop && !rx_bcast && !cfg.count_drop && !clr_pulse && !preset_pulse &&
         !rd_clr[BC0] && !rd_clr[BC0+1])
        |=> ($stable(cnt_val[BC0]) && $stable(cnt_val[BC0+1])));

    assert_rdata_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> reg_rdata == '0);
endmodule

// File: tb/test_stat_bank.sv
`timescale 1ns/1ps
module test_stat_bank;
    localparam int K_TX = 0, K_RX = 1, K_BC = 2, K_DROP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_good = 1'b0, rx_good = 1'b0, rx_bcast = 1'b0, rx_bcast_drop = 1'b0;
    logic [13:0] tx_bytes = '0, rx_bytes = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_wdata = '0;
    logic [3:0]  reg_rd_be = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stat_bank i_stat_bank (
        .clk(clk), .rst_n(rst_n), .tx_good(tx_good), .tx_bytes(tx_bytes),
        .rx_good(rx_good), .rx_bcast(rx_bcast), .rx_bcast_drop(rx_bcast_drop),
        .rx_bytes(rx_bytes), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rd_be(reg_rd_be), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [11:0] d);
        reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int a, input logic [3:0] be, output logic [31:0] v);
        reg_addr = 4'(a); reg_rd = 1'b1; reg_rd_be = be;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_rd_be = '0;
    endtask

    // read with only upper lanes strobed: never clears
    task automatic peek(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, 4'b1110, v);
        check(req, $sformatf("addr %0d", a), v, exp);
    endtask

    task automatic frame(input int kind, input int nbytes);
        tx_bytes = 14'(nbytes); rx_bytes = 14'(nbytes);
        case (kind)
            K_TX:    tx_good = 1'b1;
            K_RX:    rx_good = 1'b1;
            K_BC:    rx_bcast = 1'b1;
            default: rx_bcast_drop = 1'b1;
        endcase
        @(negedge clk);
        tx_good = 1'b0; rx_good = 1'b0; rx_bcast = 1'b0; rx_bcast_drop = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 10; a++) peek("R13", a, 32'h0);
        check("R12", "irq after reset", 32'(irq), 32'h0);
        check("R7", "rdata idle", reg_rdata, 32'h0);
    endtask

    task automatic t_count();
        frame(K_TX, 64); frame(K_TX, 100); frame(K_TX, 1500);
        frame(K_RX, 200); frame(K_RX, 300);
        frame(K_BC, 60);
        tx_good = 1'b1; tx_bytes = 14'd40; rx_good = 1'b1; rx_bytes = 14'd50;
        @(negedge clk);
        tx_good = 1'b0; rx_good = 1'b0;
        peek("R4", 1, 4); peek("R4", 2, 1704);
        peek("R4", 3, 3); peek("R4", 4, 550);
        peek("R4", 5, 1); peek("R4", 6, 60);
    endtask

    task automatic t_drop();
        frame(K_DROP, 70);
        peek("R10", 5, 1); peek("R10", 6, 60);
        wr(0, 12'h010);
        frame(K_DROP, 70);
        peek("R10", 5, 2); peek("R10", 6, 130);
        wr(0, 12'h000);
    endtask

    task automatic t_rdclr();
        logic [31:0] v;
        rd(2, 4'b1111, v); check("R7", "lane0 read, clear off", v, 1704);
        peek("R7", 2, 1704);
        wr(0, 12'h004);
        rd(1, 4'b1110, v); check("R7", "upper lanes read", v, 4);
        peek("R7", 1, 4);
        rd(1, 4'b0001, v); check("R7", "lane0 read value", v, 4);
        peek("R7", 1, 0);
    endtask

    task automatic t_rd_event();
        logic [31:0] v;
        frame(K_TX, 10);
        peek("R8", 1, 1); peek("R8", 2, 1714);
        reg_addr = 4'd2; reg_rd = 1'b1; reg_rd_be = 4'b0001;
        tx_good = 1'b1; tx_bytes = 14'd20;
        #1 v = reg_rdata;
        check("R8", "value read during event", v, 1714);
        @(negedge clk);
        reg_rd = 1'b0; reg_rd_be = '0; tx_good = 1'b0;
        peek("R8", 2, 20);
        peek("R8", 1, 2);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        wr(0, 12'h001);
        frame(K_RX, 100); frame(K_RX, 100); frame(K_BC, 80);
        peek("R9", 3, 3); peek("R9", 4, 550); peek("R9", 5, 2);
        wr(0, 12'h005);
        rd(3, 4'b0001, v); check("R9", "read under freeze", v, 3);
        peek("R9", 3, 0); peek("R9", 4, 550);
        wr(0, 12'h000);
    endtask

    task automatic t_preset();
        wr(0, 12'h040);
        peek("R2", 0, 32'h40);
        peek("R2", 0, 32'h00);
        peek("R2", 1, 32'h7FFF_FFF0); peek("R2", 2, 32'h7FFF_F800);
        peek("R2", 3, 32'h7FFF_FFF0); peek("R2", 4, 32'h7FFF_F800);
        peek("R2", 5, 32'h7FF0);      peek("R2", 6, 32'h7800);
        wr(0, 12'h048);
        peek("R2", 0, 32'h48);
        peek("R2", 0, 32'h08);
        peek("R2", 1, 32'hFFFF_FFF0); peek("R2", 2, 32'hFFFF_F800);
        peek("R2", 3, 32'hFFFF_FFF0); peek("R2", 4, 32'hFFFF_F800);
        peek("R2", 5, 32'hFFF0);      peek("R2", 6, 32'hF800);
    endtask

    task automatic t_wrap_flags();
        wr(0, 12'h040); @(negedge clk);
        peek("R11", 8, 0);
        for (int i = 0; i < 16; i++) frame(K_TX, 0);
        peek("R11", 1, 32'h8000_0000); peek("R11", 2, 32'h7FFF_F800);
        peek("R11", 8, 32'h001);
        check("R12", "irq masked off", 32'(irq), 0);
        wr(9, 12'h001);
        check("R12", "irq unmasked", 32'(irq), 1);
        wr(8, 12'h001);
        peek("R11", 8, 0);
        check("R12", "irq after flag clear", 32'(irq), 0);
        wr(0, 12'h048); @(negedge clk);
        for (int i = 0; i < 16; i++) frame(K_TX, 0);
        peek("R5", 1, 0);
        peek("R11", 8, 32'h040);
        check("R12", "irq on full flag", 32'(irq), 1);
        wr(8, 12'hFFF); wr(9, 12'h000);
    endtask

    task automatic t_saturate();
        wr(0, 12'h04A); @(negedge clk);
        for (int i = 0; i < 17; i++) frame(K_TX, 0);
        peek("R6", 1, 32'hFFFF_FFFF);
        frame(K_BC, 1500); frame(K_BC, 1500);
        peek("R6", 5, 32'hFFF2); peek("R6", 6, 32'hFFFF);
        peek("R11", 8, 32'h840);
        wr(8, 12'hFFF);
        peek("R11", 8, 0);
    endtask

    task automatic t_clear();
        wr(0, 12'h060);
        peek("R3", 0, 32'h20);
        peek("R1", 0, 32'h00);
        for (int a = 1; a <= 6; a++) peek("R3", a, 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_drop();
        t_rdclr();
        t_rd_event();
        t_freeze();
        t_preset();
        t_wrap_flags();
        t_saturate();
        t_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule